// File: doc/BRIEF.md
# Offset-Based UDP Payload Reassembler

This block sits on the receive side of a load-balanced UDP data path. Each UDP payload that reaches it has already lost its routing tag and begins with a 20-byte reassembly header. That header names the group the fragment belongs to, using a 64-bit tick and a 16-bit data id. It also carries the fragment's byte position inside the rebuilt buffer and the size of the whole buffer. Fragments arrive one byte per beat on a valid/ready stream, and they may come in any order with respect to both tick and position.

The first fragment of a (tick, data id) pair opens a context slot, and later fragments of the same pair go to the same slot. Each payload byte leaves on a write port as a slot number, a byte address and a data byte, ready for a buffer RAM beside the block. The block adds up the accepted bytes of each context. When the total reaches the buffer size, it pulses a completion with the tick, the data id, the size and the slot, and it frees the slot. Short packets, impossible sizes, fragments that run past the end of the buffer, and packets that find no free slot are reported on an error output with a code.

Top module: `reasm_engine`

## Requirements
- R1: The first 20 bytes of a packet are the header, each multi-byte field most significant byte first. Byte 0 carries the version in its upper nibble and is ignored, like byte 1. Bytes 2-3 are the data id, bytes 4-7 the byte offset, bytes 8-11 the total length and bytes 12-19 the tick.
- R2: A payload byte with index k (counted from 0 after the header) has position offset+k. When that position is below the header's length, the byte appears on the write port one cycle after it is accepted, with wr_addr equal to the position and wr_slot naming the context. Bytes at or past the length are not written.
- R3: in_ready is low during reset. After the 20th header byte of a packet that has a payload, in_ready is low for exactly one cycle, the lookup cycle. At all other times after reset it is high.
- R4: A context is identified by (tick, data id). A packet whose pair matches no open context opens a free slot. Every later packet with the same pair uses that slot, whatever the order of offsets or the interleaving with other pairs.
- R5: When a context's accepted byte count reaches its length, done_valid pulses for one cycle. The pulse comes in the cycle after the last byte of the completing packet, with done_tick, done_id, done_len and done_slot of that context, and the slot is freed.
- R6: When a packet has any payload byte at a position at or past the length, err_valid pulses with code 1 in the cycle after its last byte. None of its bytes count toward completion, and a slot that this packet opened is released.
- R7: When a header length is 0 or larger than BUF_BYTES, err_valid pulses with code 3 in the cycle after the lookup cycle. The packet's payload is consumed without writes and without effect on any context.
- R8: When a new pair finds all NUM_CTX slots open, err_valid pulses with code 2 in the cycle after the lookup cycle, and the packet is discarded as in R7.
- R9: A packet that ends within its first 20 bytes, or exactly at byte 20, is dropped, and err_valid pulses with code 0 in the cycle after its last byte.
- R10: During reset, done_valid, err_valid and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a packet |
| wr_en | output | 1 | Buffer write strobe |
| wr_slot | output | SLOT_W (2) | Context slot of the write |
| wr_addr | output | ADDR_W (8) | Byte address inside the slot buffer |
| wr_data | output | 8 | Byte to write |
| done_valid | output | 1 | Completion pulse |
| done_slot | output | SLOT_W (2) | Slot holding the completed buffer |
| done_tick | output | 64 | Tick of the completed context |
| done_id | output | 16 | Data id of the completed context |
| done_len | output | 32 | Byte length of the completed buffer |
| err_valid | output | 1 | Error pulse |
| err_code | output | 2 | 0 short, 1 out of range, 2 no free slot, 3 bad length |

## Verification
Every result is registered once. A write appears one cycle after its byte is accepted. Completion, range errors and short-packet errors appear one cycle after the last byte. Lookup errors appear one cycle after the single stall cycle, which comes right after the 20th header byte. The bench drives each byte at a falling edge and waits for the rising edge that accepts it. It then reads the outputs at the next falling edge, so each check lands on the cycle the requirement names. The stall is seen as in_ready low at the falling edge after the 20th byte, and the lookup result is read one falling edge later. Buffer contents are rebuilt from the observed write port and compared with the bytes expected at each position.

// File: rtl/reasm_pkg.sv
package reasm_pkg;
  localparam int HDR_BYTES = 20;
  localparam int HDR_KEEP  = HDR_BYTES - 2;
  localparam int LEN_W     = 32;
  localparam int TICK_W    = 64;
  localparam int ID_W      = 16;

  typedef enum logic [1:0] {
    ST_HDR     = 2'd0,
    ST_LOOKUP  = 2'd1,
    ST_PAYLOAD = 2'd2
  } parse_st_t;

  typedef enum logic [1:0] {
    ERR_SHORT  = 2'd0,
    ERR_RANGE  = 2'd1,
    ERR_NOCTX  = 2'd2,
    ERR_BADLEN = 2'd3
  } err_code_t;
endpackage

// File: rtl/reasm_hdr_parser.sv
module reasm_hdr_parser
  import reasm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic [TICK_W-1:0] hdr_tick,
  output logic [ID_W-1:0]   hdr_id,
  output logic [LEN_W-1:0]  hdr_off,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              lookup_cyc,
  output logic              pay_acc,
  output logic [LEN_W-1:0]  pay_idx,
  output logic              pkt_end,
  output logic              short_err
);
  localparam int HCNT_W = $clog2(HDR_BYTES);
  localparam int KEEP_W = 8 * HDR_KEEP;

  parse_st_t          st_q, st_n;
  logic [HCNT_W-1:0]  hcnt_q, hcnt_n;
  logic [KEEP_W-1:0]  hdr_q, hdr_n;
  logic [LEN_W-1:0]   pidx_q, pidx_n;
  logic               ready_q, ready_n;
  logic               acc, hdr_en, pidx_en;

  always_comb begin
    acc     = in_valid && ready_q;
    st_n    = st_q;
    hcnt_n  = hcnt_q;
    hdr_n   = {hdr_q[KEEP_W-9:0], in_data};
    pidx_n  = pidx_q;
    hdr_en  = 1'b0;
    pidx_en = 1'b0;
    case (st_q)
      ST_HDR: begin
        if (acc) begin
          hdr_en = 1'b1;
          if (in_last) begin
            hcnt_n = '0;
          end else if (hcnt_q == HCNT_W'(HDR_BYTES - 1)) begin
            hcnt_n = '0;
            st_n   = ST_LOOKUP;
          end else begin
            hcnt_n = hcnt_q + HCNT_W'(1);
          end
        end
      end
      ST_LOOKUP: begin
        st_n    = ST_PAYLOAD;
        pidx_n  = '0;
        pidx_en = 1'b1;
      end
      ST_PAYLOAD: begin
        if (acc) begin
          pidx_n  = pidx_q + LEN_W'(1);
          pidx_en = 1'b1;
          if (in_last) st_n = ST_HDR;
        end
      end
      default: st_n = ST_HDR;
    endcase
    ready_n = (st_n != ST_LOOKUP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HDR;
      hcnt_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      hcnt_q  <= hcnt_n;
      ready_q <= ready_n;
    end
  end

  always_ff @(posedge clk) begin
    if (hdr_en)  hdr_q  <= hdr_n;
    if (pidx_en) pidx_q <= pidx_n;
  end

  assign in_ready   = ready_q;
  assign hdr_tick   = hdr_q[63:0];
  assign hdr_len    = hdr_q[95:64];
  assign hdr_off    = hdr_q[127:96];
  assign hdr_id     = hdr_q[143:128];
  assign lookup_cyc = (st_q == ST_LOOKUP);
  assign pay_acc    = acc && (st_q == ST_PAYLOAD);
  assign pay_idx    = pidx_q;
  assign pkt_end    = pay_acc && in_last;
  assign short_err  = acc && (st_q == ST_HDR) && in_last;

  // R3: the stall after a header lasts a single cycle
  assert_ready_one_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(in_ready)) |=> in_ready);
endmodule

// File: rtl/reasm_write_path.sv
module reasm_write_path
  import reasm_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int NUM_CTX   = 4,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int SLOT_W   = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pay_acc,
  input  logic [LEN_W-1:0]  pay_idx,
  input  logic [7:0]        pay_byte,
  input  logic [LEN_W-1:0]  hdr_off,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              drop,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              pkt_end,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              end_in_range
);
  localparam int POS_W = LEN_W + 1;

  logic [POS_W-1:0]  pos;
  logic              in_range, wr_go;
  logic              ovf_q, ovf_n, ovf_en;
  logic              wr_en_q;
  logic [SLOT_W-1:0] wr_slot_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;

  always_comb begin
    pos      = {1'b0, hdr_off} + {1'b0, pay_idx};
    in_range = pos < {1'b0, hdr_len};
    wr_go    = pay_acc && !drop && in_range;
    ovf_en   = pkt_end || (pay_acc && !in_range);
    ovf_n    = pkt_end ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      if (ovf_en) ovf_q <= ovf_n;
      wr_en_q <= wr_go;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      wr_slot_q <= cur_slot;
      wr_addr_q <= pos[ADDR_W-1:0];
      wr_data_q <= pay_byte;
    end
  end

  assign end_in_range = !ovf_q && in_range;
  assign wr_en   = wr_en_q;
  assign wr_slot = wr_slot_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

  // R2: a write follows an accepted payload byte by one cycle
  assert_wr_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(pay_acc));
endmodule

// File: rtl/reasm_ctx_table.sv
module reasm_ctx_table
  import reasm_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int NUM_CTX   = 4,
  localparam int SLOT_W   = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_cyc,
  input  logic [TICK_W-1:0] hdr_tick,
  input  logic [ID_W-1:0]   hdr_id,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              pkt_end,
  input  logic [LEN_W-1:0]  pay_idx,
  input  logic              end_in_range,
  input  logic              short_err,
  output logic              drop,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              done_valid,
  output logic [SLOT_W-1:0] done_slot,
  output logic [TICK_W-1:0] done_tick,
  output logic [ID_W-1:0]   done_id,
  output logic [LEN_W-1:0]  done_len,
  output logic              err_valid,
  output logic [1:0]        err_code
);
  logic [NUM_CTX-1:0] valid_q;
  logic [TICK_W-1:0]  tick_q [NUM_CTX];
  logic [ID_W-1:0]    id_q   [NUM_CTX];
  logic [LEN_W-1:0]   len_q  [NUM_CTX];
  logic [LEN_W-1:0]   cnt_q  [NUM_CTX];

  logic [NUM_CTX-1:0] match_vec, free_vec;
  logic [SLOT_W-1:0]  match_idx, free_idx;
  logic               len_bad;
  logic               alloc_go, upd_go, release_go, done_go;
  logic [LEN_W:0]     bytes, sum;

  logic               drop_q, drop_n, new_q, new_n, cur_en;
  logic [SLOT_W-1:0]  slot_q, slot_n;
  logic               err_n, done_q, err_q;
  logic [1:0]         code_n, code_q;
  logic [SLOT_W-1:0]  dslot_q;
  logic [TICK_W-1:0]  dtick_q;
  logic [ID_W-1:0]    did_q;
  logic [LEN_W-1:0]   dlen_q;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_match
    assign match_vec[g] = valid_q[g] && (tick_q[g] == hdr_tick) && (id_q[g] == hdr_id);
    assign free_vec[g]  = !valid_q[g];
  end

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int k = NUM_CTX - 1; k >= 0; k--) begin
      if (match_vec[k]) match_idx = SLOT_W'(k);
      if (free_vec[k])  free_idx  = SLOT_W'(k);
    end
  end

  always_comb begin
    len_bad    = (hdr_len == '0) || (hdr_len > LEN_W'(BUF_BYTES));
    bytes      = {1'b0, pay_idx} + (LEN_W + 1)'(1);
    sum        = {1'b0, cnt_q[slot_q]} + bytes;
    alloc_go   = 1'b0;
    upd_go     = 1'b0;
    release_go = 1'b0;
    done_go    = 1'b0;
    err_n      = 1'b0;
    code_n     = code_q;
    drop_n     = drop_q;
    new_n      = new_q;
    slot_n     = slot_q;
    cur_en     = 1'b0;
    if (short_err) begin
      err_n  = 1'b1;
      code_n = ERR_SHORT;
    end
    if (lookup_cyc) begin
      cur_en = 1'b1;
      new_n  = 1'b0;
      drop_n = 1'b0;
      if (len_bad) begin
        err_n  = 1'b1;
        code_n = ERR_BADLEN;
        drop_n = 1'b1;
      end else if (|match_vec) begin
        slot_n = match_idx;
      end else if (|free_vec) begin
        slot_n   = free_idx;
        new_n    = 1'b1;
        alloc_go = 1'b1;
      end else begin
        err_n  = 1'b1;
        code_n = ERR_NOCTX;
        drop_n = 1'b1;
      end
    end
    if (pkt_end && !drop_q) begin
      if (!end_in_range) begin
        err_n      = 1'b1;
        code_n     = ERR_RANGE;
        release_go = new_q;
      end else if (sum >= {1'b0, len_q[slot_q]}) begin
        done_go    = 1'b1;
        release_go = 1'b1;
      end else begin
        upd_go = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (alloc_go && (free_idx == SLOT_W'(g))) begin
        valid_q[g] <= 1'b1;
      end else if (release_go && (slot_q == SLOT_W'(g))) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_go && (free_idx == SLOT_W'(g))) begin
        tick_q[g] <= hdr_tick;
        id_q[g]   <= hdr_id;
        len_q[g]  <= hdr_len;
        cnt_q[g]  <= '0;
      end else if (upd_go && (slot_q == SLOT_W'(g))) begin
        cnt_q[g]  <= sum[LEN_W-1:0];
      end
    end

    // R5: an open context never holds its full length
    assert_count_below_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[g] |-> (cnt_q[g] < len_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
      new_q  <= 1'b0;
      slot_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
    end else begin
      if (cur_en) begin
        drop_q <= drop_n;
        new_q  <= new_n;
        slot_q <= slot_n;
      end
      done_q <= done_go;
      err_q  <= err_n;
      if (err_n) code_q <= code_n;
    end
  end

  always_ff @(posedge clk) begin
    if (done_go) begin
      dslot_q <= slot_q;
      dtick_q <= tick_q[slot_q];
      did_q   <= id_q[slot_q];
      dlen_q  <= len_q[slot_q];
    end
  end

  assign drop       = drop_q;
  assign cur_slot   = slot_q;
  assign done_valid = done_q;
  assign done_slot  = dslot_q;
  assign done_tick  = dtick_q;
  assign done_id    = did_q;
  assign done_len   = dlen_q;
  assign err_valid  = err_q;
  assign err_code   = code_q;

  // R4: no two open contexts share a (tick, data id) pair
  assert_unique_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_cyc |-> $onehot0(match_vec));
  // R5: completion only follows the last byte of a packet
  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(pkt_end));
  // R6: a packet never both completes and errors
  assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && err_valid));
endmodule

// File: rtl/reasm_engine.sv
module reasm_engine
  import reasm_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  parameter int NUM_CTX   = 4,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int SLOT_W   = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done_valid,
  output logic [SLOT_W-1:0] done_slot,
  output logic [63:0]       done_tick,
  output logic [15:0]       done_id,
  output logic [31:0]       done_len,
  output logic              err_valid,
  output logic [1:0]        err_code
);
  logic [TICK_W-1:0] hdr_tick;
  logic [ID_W-1:0]   hdr_id;
  logic [LEN_W-1:0]  hdr_off, hdr_len, pay_idx;
  logic              lookup_cyc, pay_acc, pkt_end, short_err;
  logic              drop, end_in_range;
  logic [SLOT_W-1:0] cur_slot;

  reasm_hdr_parser u_parser (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .hdr_tick(hdr_tick), .hdr_id(hdr_id), .hdr_off(hdr_off), .hdr_len(hdr_len),
    .lookup_cyc(lookup_cyc), .pay_acc(pay_acc), .pay_idx(pay_idx),
    .pkt_end(pkt_end), .short_err(short_err)
  );

  reasm_write_path #(.BUF_BYTES(BUF_BYTES), .NUM_CTX(NUM_CTX)) u_wpath (
    .clk(clk), .rst_n(rst_n),
    .pay_acc(pay_acc), .pay_idx(pay_idx), .pay_byte(in_data),
    .hdr_off(hdr_off), .hdr_len(hdr_len), .drop(drop), .cur_slot(cur_slot),
    .pkt_end(pkt_end),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr), .wr_data(wr_data),
    .end_in_range(end_in_range)
  );

  reasm_ctx_table #(.BUF_BYTES(BUF_BYTES), .NUM_CTX(NUM_CTX)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .lookup_cyc(lookup_cyc), .hdr_tick(hdr_tick), .hdr_id(hdr_id), .hdr_len(hdr_len),
    .pkt_end(pkt_end), .pay_idx(pay_idx), .end_in_range(end_in_range),
    .short_err(short_err),
    .drop(drop), .cur_slot(cur_slot),
    .done_valid(done_valid), .done_slot(done_slot), .done_tick(done_tick),
    .done_id(done_id), .done_len(done_len),
    .err_valid(err_valid), .err_code(err_code)
  );
endmodule

// File: tb/reasm_engine_bench.sv
`timescale 1ns/1ps
module reasm_engine_bench;
  localparam int BUF  = 256;
  localparam int NCTX = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        wr_en;
  logic [1:0]  wr_slot;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        done_valid;
  logic [1:0]  done_slot;
  logic [63:0] done_tick;
  logic [15:0] done_id;
  logic [31:0] done_len;
  logic        err_valid;
  logic [1:0]  err_code;

  int tests = 0;
  int fails = 0;

  logic [7:0]  bm [NCTX*BUF];
  logic        end_done, end_err, lk_err;
  logic [1:0]  end_code, lk_code;
  logic [63:0] d_tick;
  logic [15:0] d_id;
  logic [31:0] d_len;
  logic [1:0]  d_slot;

  always #4 clk = ~clk;

  reasm_engine u_reasm_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_valid(done_valid), .done_slot(done_slot), .done_tick(done_tick),
    .done_id(done_id), .done_len(done_len),
    .err_valid(err_valid), .err_code(err_code)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en) bm[int'(wr_slot)*BUF + int'(wr_addr)] = wr_data;
  end

  function automatic logic [7:0] fbyte(input int seed, input int p);
    return 8'((seed * 13 + p * 7 + (p >> 3)) & 255);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] tick, input logic [15:0] id,
                      input int off, input int len, input int n,
                      input int seed, input string req);
    logic [7:0] hb [20];
    logic [7:0] b;
    int pos;
    logic exp_wr;
    hb[0] = 8'h10; hb[1] = 8'h00;
    hb[2] = id[15:8]; hb[3] = id[7:0];
    for (int j = 0; j < 4; j++) begin
      hb[4 + j] = 8'(off >> (24 - 8 * j));
      hb[8 + j] = 8'(len >> (24 - 8 * j));
    end
    for (int j = 0; j < 8; j++) hb[12 + j] = tick[63 - 8 * j -: 8];
    lk_err = 1'b0; lk_code = 2'd0;
    for (int i = 0; i < 20 + n; i++) begin
      b = (i < 20) ? hb[i] : fbyte(seed, off + i - 20);
      in_valid = 1'b1; in_data = b; in_last = (i == 20 + n - 1);
      if (i == 20) begin
        @(negedge clk);
        lk_err = err_valid; lk_code = err_code;
        chk("R3", "ready back after lookup", {63'd0, in_ready}, 64'd1);
      end
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      if (i == 19 && n > 0) chk("R3", "stall after header", {63'd0, in_ready}, 64'd0);
      if (i >= 20) begin
        pos = off + i - 20;
        exp_wr = !lk_err && (pos < len);
        chk(req, "write strobe", {63'd0, wr_en}, {63'd0, exp_wr});
        if (exp_wr) begin
          chk("R2", "write address", {56'd0, wr_addr}, 64'(pos));
          chk("R2", "write data", {56'd0, wr_data}, {56'd0, fbyte(seed, pos)});
        end
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    end_done = done_valid; end_err = err_valid; end_code = err_code;
    d_tick = done_tick; d_id = done_id; d_len = done_len; d_slot = done_slot;
  endtask

  task automatic send_short(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = 8'(i * 3); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    end_done = done_valid; end_err = err_valid; end_code = err_code;
  endtask

  task automatic check_buf(input logic [1:0] slot, input int len, input int seed,
                           input string req);
    int bad = 0;
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < len; p++)
      if (bm[int'(slot)*BUF + p] !== fbyte(seed, p)) bad++;
    chk(req, "buffer content mismatches", 64'(bad), 64'd0);
  endtask

  task automatic chk_done(input string req, input logic [63:0] tick,
                          input logic [15:0] id, input int len);
    chk(req, "done pulse", {63'd0, end_done}, 64'd1);
    chk(req, "done tick", d_tick, tick);
    chk(req, "done id", {48'd0, d_id}, {48'd0, id});
    chk(req, "done length", {32'd0, d_len}, 64'(len));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R3", "ready in reset", {63'd0, in_ready}, 64'd0);
    chk("R10", "done in reset", {63'd0, done_valid}, 64'd0);
    chk("R10", "err in reset", {63'd0, err_valid}, 64'd0);
    chk("R10", "wr_en in reset", {63'd0, wr_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3", "ready after reset", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_single;
    send(64'h0102030405060708, 16'hA5C3, 0, 16, 16, 3, "R2");
    chk("R1", "no lookup error", {63'd0, lk_err}, 64'd0);
    chk_done("R5", 64'h0102030405060708, 16'hA5C3, 16);
    check_buf(d_slot, 16, 3, "R1");
  endtask

  task automatic t_out_of_order;
    send(64'hFEDC000000000011, 16'h0002, 8, 12, 4, 5, "R2");
    chk("R4", "no done after first", {63'd0, end_done}, 64'd0);
    send(64'hFEDC000000000011, 16'h0002, 0, 12, 4, 5, "R2");
    chk("R4", "no done after second", {63'd0, end_done}, 64'd0);
    send(64'hFEDC000000000011, 16'h0002, 4, 12, 4, 5, "R2");
    chk_done("R4", 64'hFEDC000000000011, 16'h0002, 12);
    check_buf(d_slot, 12, 5, "R4");
  endtask

  task automatic t_interleave;
    logic [1:0] sa;
    send(64'h33, 16'h5, 4, 8, 4, 10, "R2");
    send(64'h33, 16'h6, 0, 8, 4, 11, "R2");
    send(64'h44, 16'h5, 4, 8, 4, 12, "R2");
    chk("R4", "no early done", {63'd0, end_done}, 64'd0);
    send(64'h33, 16'h5, 0, 8, 4, 10, "R2");
    chk_done("R4", 64'h33, 16'h5, 8);
    sa = d_slot;
    check_buf(d_slot, 8, 10, "R4");
    send(64'h44, 16'h5, 0, 8, 4, 12, "R2");
    chk_done("R4", 64'h44, 16'h5, 8);
    chk("R4", "distinct slot", {63'd0, d_slot != sa}, 64'd1);
    check_buf(d_slot, 8, 12, "R4");
    send(64'h33, 16'h6, 4, 8, 4, 11, "R2");
    chk_done("R4", 64'h33, 16'h6, 8);
    check_buf(d_slot, 8, 11, "R4");
  endtask

  task automatic t_range;
    send(64'h55, 16'h7, 0, 8, 6, 20, "R2");
    chk("R6", "no done on partial", {63'd0, end_done}, 64'd0);
    send(64'h55, 16'h7, 6, 8, 4, 20, "R6");
    chk("R6", "range error", {63'd0, end_err}, 64'd1);
    chk("R6", "range code", {62'd0, end_code}, 64'd1);
    chk("R6", "no done on reject", {63'd0, end_done}, 64'd0);
    send(64'h55, 16'h7, 6, 8, 2, 20, "R2");
    chk_done("R6", 64'h55, 16'h7, 8);
    check_buf(d_slot, 8, 20, "R6");
  endtask

  task automatic t_badlen;
    send(64'h66, 16'h1, 0, 0, 4, 30, "R7");
    chk("R7", "lookup error len 0", {63'd0, lk_err}, 64'd1);
    chk("R7", "code len 0", {62'd0, lk_code}, 64'd3);
    chk("R7", "no end event", {62'd0, end_done, end_err}, 64'd0);
    send(64'h66, 16'h1, 0, BUF + 1, 4, 30, "R7");
    chk("R7", "lookup error oversize", {63'd0, lk_err}, 64'd1);
    chk("R7", "code oversize", {62'd0, lk_code}, 64'd3);
  endtask

  task automatic t_noctx;
    for (int i = 0; i < NCTX; i++) begin
      send(64'hC0 + 64'(i), 16'(i), 4, 8, 8, 40 + i, "R6");
      chk("R6", "reject first packet", {62'd0, end_code}, 64'd1);
    end
    for (int i = 0; i < NCTX; i++) begin
      send(64'hD0 + 64'(i), 16'(i), 0, 8, 4, 50 + i, "R2");
      chk("R8", "slot available", {63'd0, lk_err}, 64'd0);
    end
    send(64'hD9, 16'h9, 0, 8, 4, 59, "R8");
    chk("R8", "table full error", {63'd0, lk_err}, 64'd1);
    chk("R8", "table full code", {62'd0, lk_code}, 64'd2);
    chk("R8", "no end event", {62'd0, end_done, end_err}, 64'd0);
    send(64'hD0, 16'h0, 4, 8, 4, 50, "R2");
    chk_done("R5", 64'hD0, 16'h0, 8);
    send(64'hD9, 16'h9, 0, 8, 4, 59, "R2");
    chk("R8", "retry opens slot", {63'd0, lk_err}, 64'd0);
    for (int i = 1; i < NCTX; i++) begin
      send(64'hD0 + 64'(i), 16'(i), 4, 8, 4, 50 + i, "R2");
      chk_done("R5", 64'hD0 + 64'(i), 16'(i), 8);
    end
    send(64'hD9, 16'h9, 4, 8, 4, 59, "R2");
    chk_done("R5", 64'hD9, 16'h9, 8);
    check_buf(d_slot, 8, 59, "R5");
  endtask

  task automatic t_short;
    send_short(10);
    chk("R9", "short error", {63'd0, end_err}, 64'd1);
    chk("R9", "short code", {62'd0, end_code}, 64'd0);
    send_short(20);
    chk("R9", "header-only error", {63'd0, end_err}, 64'd1);
    chk("R9", "header-only code", {62'd0, end_code}, 64'd0);
    chk("R3", "no stall after header-only", {63'd0, in_ready}, 64'd1);
    send(64'h77, 16'h3, 0, 5, 5, 60, "R2");
    chk_done("R9", 64'h77, 16'h3, 5);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_out_of_order();
    t_interleave();
    t_range();
    t_badlen();
    t_noctx();
    t_short();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule